// File: doc/BRIEF.md
# Protected Byte-Store Write/Read Sequencer

This block sits between a processor's register port and a byte-wide nonvolatile data store of 512 locations. Software reaches it through three registers. The location register holds a 9-bit address. The byte register holds the data to be stored, or the data just fetched. The command register holds four bits: a ready-interrupt enable, an arm bit, a store strobe and a fetch strobe.

A store needs two steps. Software first sets the arm bit. The arm bit clears itself after a short window. Software must then raise the store strobe before that window closes. The store strobe stays high for the whole programming time, and software can poll it. A fetch copies the addressed byte into the byte register on the clock edge that takes the request.

While a store is in progress, fetches are dropped and the location register is frozen. The block asks the processor to stall for a fixed number of cycles after each fetch and after each store start. It raises a level interrupt whenever the store is idle and both the local enable and the global enable are set.

Top module: `nvbyte_seq`

## Requirements
- R1: After reset the command register (bit 3 ready enable, bit 2 arm, bit 1 store strobe, bit 0 fetch strobe) and the location register read zero, and `cpu_stall` and `ready_irq` are low.
- R2: A command write (`reg_sel`=2) with bit 2 set and bit 1 clear sets the arm bit. The arm bit reads 1 for exactly four cycles after that write and then clears by itself.
- R3: A command write with bit 1 set starts a store only if the arm bit is set when the write is taken. Otherwise it has no effect: the store strobe reads 0 and the stored byte is unchanged. Starting a store clears the arm bit.
- R4: Once a store starts, the store strobe reads 1 for exactly `WR_LAT` cycles and then clears by itself.
- R5: `ready_irq` is high exactly when the ready enable bit is set, `gie` is high and no store is in progress.
- R6: A command write with bit 0 set, while no store is in progress, loads the byte register from the array at the current address on the same edge. The fetch strobe reads 1 for one cycle only.
- R7: `cpu_stall` is high for four cycles after a fetch is taken and for two cycles after a store starts.
- R8: While a store is in progress, fetch requests leave the byte register and the fetch strobe unchanged, and writes to the location register (`reg_sel`=0) are ignored. Writes to the byte register (`reg_sel`=1) still take effect.
- R9: A stored byte is returned by a later fetch at the same address. The lowest and highest addresses (0 and 511) hold separate values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| gie | input | 1 | Processor global interrupt enable |
| reg_wr | input | 1 | Register write request, one cycle |
| reg_sel | input | 2 | Register select: 0 location, 1 byte, 2 command, 3 none |
| reg_wdata | input | 9 | Write data; low bits used for byte and command |
| addr_rd | output | 9 | Location register contents |
| data_rd | output | 8 | Byte register contents |
| ctrl_rd | output | 4 | Command register contents |
| cpu_stall | output | 1 | Processor stall request |
| ready_irq | output | 1 | Store-ready interrupt, level |

## Verification
Some rules are checked on every cycle by the assertions. A store may only begin from an armed state, and it starts with a stall. The arm bit never outlives its four-cycle window. The store strobe falls exactly `WR_LAT` cycles after it rises. The fetch strobe never lasts two cycles. The location register holds still during a store, and the interrupt stays low while a store is in progress. Other behaviour depends on the data actually held in the array, or on exact edges, so only the bench scenarios can show it. These cases are: the arm window accepting a strobe on its last cycle and refusing it one cycle later, a refused strobe leaving the old byte in place, a fetch being ignored during a store, and the two end addresses keeping separate values.

// File: rtl/nvb_pkg.sv
package nvb_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // command register bit positions
  localparam int CB_RDY = 3;
  localparam int CB_ARM = 2;
  localparam int CB_WST = 1;
  localparam int CB_RST = 0;

  localparam int             WIN_W      = 3;
  localparam logic [WIN_W-1:0] ARM_CYCLES = 3'd4;
  localparam logic [WIN_W-1:0] RD_STALL   = 3'd4;
  localparam logic [WIN_W-1:0] WR_STALL   = 3'd2;
endpackage

// File: rtl/nvb_countdown.sv
module nvb_countdown #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         active
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/nvb_array.sv
module nvb_array #(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/nvbyte_seq.sv
module nvbyte_seq
  import nvb_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 8,
  parameter int WR_LAT = 24,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int BUS_W  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gie,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [ADDR_W-1:0] addr_rd,
  output logic [DATA_W-1:0] data_rd,
  output logic [3:0]        ctrl_rd,
  output logic              cpu_stall,
  output logic              ready_irq
);
  localparam int LAT_W = $clog2(WR_LAT + 1);
  localparam logic [LAT_W-1:0] LAT_LOAD = LAT_W'(WR_LAT);

  // reset: asserted asynchronously, released on the clock
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  logic srst_n;
  assign srst_n = rst_s2_q;

  // request decode
  logic wr_addr, wr_data, wr_ctrl;
  assign wr_addr = reg_wr && (reg_sel == SEL_ADDR);
  assign wr_data = reg_wr && (reg_sel == SEL_DATA);
  assign wr_ctrl = reg_wr && (reg_sel == SEL_CTRL);

  logic armed, busy;
  logic arm_set, store_go, fetch_go;
  assign arm_set  = wr_ctrl && reg_wdata[CB_ARM] && !reg_wdata[CB_WST];
  assign store_go = wr_ctrl && reg_wdata[CB_WST] && armed && !busy;
  assign fetch_go = wr_ctrl && reg_wdata[CB_RST] && !busy;

  // arm window: reload on set, cancel on store start
  logic [WIN_W-1:0] arm_val;
  assign arm_val = arm_set ? ARM_CYCLES : '0;
  nvb_countdown #(.W(WIN_W)) u_arm (
    .clk(clk), .rst_n(srst_n),
    .load(arm_set || store_go), .load_val(arm_val),
    .active(armed)
  );

  // programming time
  nvb_countdown #(.W(LAT_W)) u_prog (
    .clk(clk), .rst_n(srst_n),
    .load(store_go), .load_val(LAT_LOAD),
    .active(busy)
  );

  // processor stall
  logic [WIN_W-1:0] stall_val;
  assign stall_val = fetch_go ? RD_STALL : WR_STALL;
  nvb_countdown #(.W(WIN_W)) u_stall (
    .clk(clk), .rst_n(srst_n),
    .load(fetch_go || store_go), .load_val(stall_val),
    .active(cpu_stall)
  );

  // registers
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              rdy_en_q, rdy_en_d;
  logic              fstb_q, fstb_d;
  logic [DATA_W-1:0] arr_rdata;

  nvb_array #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .we(store_go),
    .waddr(addr_q), .wdata(data_q),
    .raddr(addr_q), .rdata(arr_rdata)
  );

  always_comb begin
    addr_d = addr_q;
    if (wr_addr && !busy)
      addr_d = reg_wdata[ADDR_W-1:0];
    data_d = data_q;
    if (wr_data)
      data_d = reg_wdata[DATA_W-1:0];
    else if (fetch_go)
      data_d = arr_rdata;
    rdy_en_d = wr_ctrl ? reg_wdata[CB_RDY] : rdy_en_q;
    fstb_d   = fetch_go;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      addr_q   <= '0;
      data_q   <= '0;
      rdy_en_q <= 1'b0;
      fstb_q   <= 1'b0;
    end else begin
      if (wr_addr || wr_data || fetch_go || wr_ctrl || fstb_q) begin
        addr_q   <= addr_d;
        data_q   <= data_d;
        rdy_en_q <= rdy_en_d;
        fstb_q   <= fstb_d;
      end
    end
  end

  assign addr_rd   = addr_q;
  assign data_rd   = data_q;
  assign ctrl_rd   = {rdy_en_q, armed, busy, fstb_q};
  assign ready_irq = rdy_en_q && gie && !busy;
endmodule

// File: rtl/nvbyte_seq_checker.sv
module nvbyte_seq_checker #(
  parameter int WR_LAT = 24,
  parameter int ADDR_W = 9,
  parameter int BUS_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [1:0]        reg_sel,
  input logic [BUS_W-1:0]  reg_wdata,
  input logic [ADDR_W-1:0] addr_rd,
  input logic [3:0]        ctrl_rd,
  input logic              cpu_stall,
  input logic              ready_irq
);
  logic arm, busy, fstb, arm_wr;
  assign arm    = ctrl_rd[2];
  assign busy   = ctrl_rd[1];
  assign fstb   = ctrl_rd[0];
  assign arm_wr = reg_wr && (reg_sel == 2'd2) && reg_wdata[2] && !reg_wdata[1];

  logic [2:0]  arm_age;
  logic [31:0] busy_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_age  <= '0;
      busy_len <= '0;
    end else begin
      arm_age  <= (!arm || arm_wr) ? 3'd0 : arm_age + 3'd1;
      busy_len <= busy ? busy_len + 32'd1 : 32'd0;
    end
  end

  p_arm_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    arm |-> (arm_age < 3'd4));
  p_store_needs_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(arm));
  p_store_length_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == 32'(WR_LAT)));
  p_irq_quiet_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ready_irq);
  p_fetch_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fstb |=> !fstb);
  p_store_stalls_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> cpu_stall);
  p_addr_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(addr_rd));
endmodule

bind nvbyte_seq nvbyte_seq_checker #(
  .WR_LAT(WR_LAT), .ADDR_W(ADDR_W), .BUS_W(BUS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .addr_rd(addr_rd), .ctrl_rd(ctrl_rd),
  .cpu_stall(cpu_stall), .ready_irq(ready_irq)
);

// File: tb/nvbyte_seq_test.sv
module nvbyte_seq_test;
  localparam int WR_LAT = 24;

  logic       clk, rst_n, gie, reg_wr;
  logic [1:0] reg_sel;
  logic [8:0] reg_wdata;
  logic [8:0] addr_rd;
  logic [7:0] data_rd;
  logic [3:0] ctrl_rd;
  logic       cpu_stall, ready_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  nvbyte_seq #(.WR_LAT(WR_LAT)) uut (
    .clk(clk), .rst_n(rst_n), .gie(gie), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .addr_rd(addr_rd),
    .data_rd(data_rd), .ctrl_rd(ctrl_rd), .cpu_stall(cpu_stall),
    .ready_irq(ready_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] sel, input logic [8:0] val);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 2'd3; reg_wdata = '0;
  endtask

  task automatic wait_idle();
    while (ctrl_rd[1]) @(negedge clk);
  endtask

  task automatic store(input logic [8:0] a, input logic [7:0] d);
    wreg(2'd0, a);
    wreg(2'd1, {1'b0, d});
    wreg(2'd2, 9'h004);
    wreg(2'd2, 9'h002);
    wait_idle();
  endtask

  task automatic fetch(input logic [8:0] a);
    wreg(2'd0, a);
    wreg(2'd2, 9'h001);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 ctrl", 16'(ctrl_rd), 16'h0);
    check("R1 addr", 16'(addr_rd), 16'h0);
    check("R1 stall", 16'(cpu_stall), 16'h0);
    check("R1 irq", 16'(ready_irq), 16'h0);
  endtask

  task automatic t_arm_window();
    wreg(2'd2, 9'h004);
    check("R2 arm set", 16'(ctrl_rd[2]), 16'h1);
    repeat (3) @(negedge clk);
    check("R2 arm last cycle", 16'(ctrl_rd[2]), 16'h1);
    @(negedge clk);
    check("R2 arm cleared", 16'(ctrl_rd[2]), 16'h0);
  endtask

  task automatic t_store_last_cycle();
    wreg(2'd0, 9'h005);
    wreg(2'd1, 9'h011);
    wreg(2'd2, 9'h004);
    repeat (2) @(negedge clk);
    wreg(2'd2, 9'h002);
    check("R3 accepted on last armed cycle", 16'(ctrl_rd[1]), 16'h1);
    check("R3 arm consumed", 16'(ctrl_rd[2]), 16'h0);
    for (int k = 0; k < WR_LAT; k++) begin
      check("R4 strobe held", 16'(ctrl_rd[1]), 16'h1);
      check("R7 store stall", 16'(cpu_stall), 16'(k < 2));
      @(negedge clk);
    end
    check("R4 strobe cleared", 16'(ctrl_rd[1]), 16'h0);
  endtask

  task automatic t_store_refused();
    wreg(2'd1, 9'h099);
    wreg(2'd2, 9'h002);
    check("R3 no arm no store", 16'(ctrl_rd[1]), 16'h0);
    check("R3 no arm no stall", 16'(cpu_stall), 16'h0);
    wreg(2'd2, 9'h004);
    repeat (3) @(negedge clk);
    wreg(2'd2, 9'h002);
    check("R3 late strobe refused", 16'(ctrl_rd[1]), 16'h0);
    fetch(9'h005);
    check("R3 byte unchanged", 16'(data_rd), 16'h11);
  endtask

  task automatic t_fetch();
    wreg(2'd0, 9'h005);
    wreg(2'd1, 9'h000);
    wreg(2'd2, 9'h001);
    check("R6 byte loaded", 16'(data_rd), 16'h11);
    check("R6 fetch strobe", 16'(ctrl_rd[0]), 16'h1);
    check("R7 fetch stall", 16'(cpu_stall), 16'h1);
    @(negedge clk);
    check("R6 fetch strobe clears", 16'(ctrl_rd[0]), 16'h0);
    repeat (2) @(negedge clk);
    check("R7 fetch stall cycle 4", 16'(cpu_stall), 16'h1);
    @(negedge clk);
    check("R7 fetch stall ends", 16'(cpu_stall), 16'h0);
  endtask

  task automatic t_lockout();
    wreg(2'd0, 9'h040);
    wreg(2'd1, 9'h0C3);
    wreg(2'd2, 9'h004);
    wreg(2'd2, 9'h002);
    wreg(2'd0, 9'h041);
    check("R8 addr frozen", 16'(addr_rd), 16'h040);
    wreg(2'd1, 9'h05A);
    check("R8 byte reg writable", 16'(data_rd), 16'h5A);
    wreg(2'd2, 9'h001);
    check("R8 fetch ignored data", 16'(data_rd), 16'h5A);
    check("R8 fetch ignored strobe", 16'(ctrl_rd[0]), 16'h0);
    wait_idle();
    fetch(9'h040);
    check("R9 stored value", 16'(data_rd), 16'hC3);
  endtask

  task automatic t_ends();
    store(9'h1FF, 8'hA5);
    store(9'h000, 8'h3C);
    fetch(9'h1FF);
    check("R9 top address", 16'(data_rd), 16'hA5);
    fetch(9'h000);
    check("R9 bottom address", 16'(data_rd), 16'h3C);
  endtask

  task automatic t_irq();
    gie = 1'b1;
    wreg(2'd2, 9'h008);
    check("R5 irq idle", 16'(ready_irq), 16'h1);
    wreg(2'd2, 9'h00C);
    wreg(2'd2, 9'h00A);
    check("R5 irq low while storing", 16'(ready_irq), 16'h0);
    wait_idle();
    check("R5 irq back", 16'(ready_irq), 16'h1);
    @(negedge clk);
    gie = 1'b0;
    #1;
    check("R5 irq gated by gie", 16'(ready_irq), 16'h0);
  endtask

  initial begin
    rst_n = 1'b0; gie = 1'b0; reg_wr = 1'b0; reg_sel = 2'd3; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_arm_window();
    t_store_last_cycle();
    t_store_refused();
    t_fetch();
    t_lockout();
    t_ends();
    t_irq();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule